// File: doc/BRIEF.md
# Serial Record Framer with Flow-Control Filter

This block sits behind a UART receiver and turns its byte stream into text records. A record opens on the letter `S` and closes on a line feed. Bytes seen while no record is open are dropped and counted. The in-band flow-control bytes are taken out of the stream wherever they appear, and they set or clear a pause request for a local transmitter.

A small table of programmable control characters lets software mark bytes for rejection. A rejected byte never reaches the record stream. It is latched into a last-control-character register and raises a one-cycle event.

Downstream logic sees one byte per beat, with start-of-record and end-of-record markers. An overflow flag marks a record that exceeded the buffer capacity. A carriage return directly ahead of the line feed is removed.

Top module: `rec_framer`

## Requirements
- R1: All outputs are registered. The result of a byte sampled on a rising edge appears in the cycle that follows that edge. The input is never valid in two consecutive cycles, which is the spacing of a UART receiver.
- R2: While no record is open, a data byte 0x53 (`S`) opens a record. It is output with `out_sof` high.
- R3: While no record is open, every other data byte (including CR and LF) is dropped and `discard_cnt` increments by one, wrapping at its width. Flow-control and rejected bytes are never counted.
- R4: XON (0x11) and XOFF (0x13) never appear on `out_data`, whatever the framer state. They do not disturb an open record or a pending CR.
- R5: `tx_pause` is low after reset. It goes high in the cycle after an XOFF and low in the cycle after an XON.
- R6: A byte that equals an entry of the control table whose enable bit and reject bit are both set is not output. It is loaded into `ctl_last` and `ctl_evt` pulses for one cycle. Entries that are disabled, or enabled without the reject bit, have no effect. Flow-control detection takes precedence over the table.
- R7: Inside a record, LF (0x0A) is output with `out_eof` high and closes the record, after which the framer hunts for `S` again.
- R8: A CR (0x0D) inside a record is held. If the next data byte is LF, the CR is dropped. Otherwise the CR is output on that byte's cycle and the byte follows one cycle later, being processed as a normal data byte at that time.
- R9: A record holds at most `MAX_LEN` output bytes, counting `S` and LF. A byte that would exceed this gives `out_eof` and `out_ovf` high with `out_valid` low. The byte is dropped and the framer hunts for `S`.
- R10: Reset clears the framer to the hunt state. All output strobes are low and `ctl_last` and `discard_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| tab_char | input | NCTL*8 | Control-table characters, entry i in bits [8i+7:8i] |
| tab_en | input | NCTL | Control-table entry enables |
| tab_rej | input | NCTL | Control-table reject bits |
| out_valid | output | 1 | Record byte strobe |
| out_data | output | 8 | Record byte |
| out_sof | output | 1 | First byte of a record |
| out_eof | output | 1 | Record closed (with or without a byte) |
| out_ovf | output | 1 | Record closed by overflow |
| tx_pause | output | 1 | Pause request for the local transmitter |
| ctl_evt | output | 1 | Rejected control character seen |
| ctl_last | output | 8 | Last rejected control character |
| discard_cnt | output | CNT_W | Count of bytes dropped outside records |

## Verification
Every result of a sampled byte is due in the cycle after that rising edge. The one exception is the byte that follows a held CR, which leaves the block one cycle later still. The bench drives each byte on a falling edge and samples the first-cycle results on the next falling edge. It then samples again one falling edge later to catch the delayed byte. Because inputs are driven only every other cycle, no two stimuli overlap inside these windows.

// File: rtl/rec_framer_pkg.sv
package rec_framer_pkg;

    localparam logic [7:0] CH_RESUME = 8'h11;
    localparam logic [7:0] CH_PAUSE  = 8'h13;
    localparam logic [7:0] CH_START  = 8'h53;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] CH_CR     = 8'h0D;

    typedef enum logic [1:0] {
        BK_DATA   = 2'd0,
        BK_RESUME = 2'd1,
        BK_PAUSE  = 2'd2,
        BK_REJECT = 2'd3
    } byte_kind_e;

    typedef struct packed {
        logic       vld;
        byte_kind_e kind;
        logic [7:0] val;
    } tagged_byte_t;

    typedef enum logic {
        FS_HUNT = 1'b0,
        FS_OPEN = 1'b1
    } frame_st_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] val;
        logic       sof;
        logic       eof;
        logic       ovf;
    } rec_beat_t;

    function automatic byte_kind_e flow_kind(input logic [7:0] b);
        if (b == CH_RESUME)     return BK_RESUME;
        else if (b == CH_PAUSE) return BK_PAUSE;
        else                    return BK_DATA;
    endfunction

endpackage

// File: rtl/rf_classify.sv
module rf_classify
    import rec_framer_pkg::*;
#(
    parameter int NCTL = 4
) (
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [NCTL*8-1:0] tab_char,
    input  logic [NCTL-1:0]   tab_en,
    input  logic [NCTL-1:0]   tab_rej,
    output tagged_byte_t      tb
);

    logic [NCTL-1:0] hit;

    for (genvar i = 0; i < NCTL; i++) begin : g_entry
        assign hit[i] = tab_en[i] & tab_rej[i] & (tab_char[i*8 +: 8] == in_data);
    end

    always_comb begin
        tb.vld  = in_valid;
        tb.val  = in_data;
        tb.kind = flow_kind(in_data);
        if (tb.kind == BK_DATA && |hit) tb.kind = BK_REJECT;
    end

endmodule

// File: rtl/rf_side.sv
module rf_side
    import rec_framer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  tagged_byte_t tb,
    output logic         tx_pause,
    output logic         ctl_evt,
    output logic [7:0]   ctl_last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pause <= 1'b0;
            ctl_evt  <= 1'b0;
            ctl_last <= 8'h00;
        end else begin
            ctl_evt <= 1'b0;
            if (tb.vld) begin
                unique case (tb.kind)
                    BK_PAUSE:  tx_pause <= 1'b1;
                    BK_RESUME: tx_pause <= 1'b0;
                    BK_REJECT: begin
                        ctl_evt  <= 1'b1;
                        ctl_last <= tb.val;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rf_frame.sv
module rf_frame
    import rec_framer_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tagged_byte_t     tb,
    output rec_beat_t        beat,
    output logic [CNT_W-1:0] discard_cnt
);

    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(MAX_LEN);

    frame_st_e        st_q, st_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic             cr_q, cr_n;
    logic             sp_v_q, sp_v_n;
    logic [7:0]       sp_b_q, sp_b_n;
    rec_beat_t        beat_q, beat_n;
    logic [CNT_W-1:0] disc_q, disc_n;

    logic             d_v;
    logic [7:0]       d_b;
    logic             em, cl, rs;
    logic [7:0]       eb;

    always_comb begin
        d_v    = sp_v_q | (tb.vld && tb.kind == BK_DATA);
        d_b    = sp_v_q ? sp_b_q : tb.val;
        st_n   = st_q;
        len_n  = len_q;
        cr_n   = cr_q;
        sp_v_n = 1'b0;
        sp_b_n = sp_b_q;
        beat_n = '0;
        disc_n = disc_q;
        em     = 1'b0;
        cl     = 1'b0;
        rs     = 1'b0;
        eb     = d_b;
        if (d_v) begin
            if (st_q == FS_HUNT) begin
                if (d_b == CH_START) begin
                    st_n       = FS_OPEN;
                    len_n      = LEN_W'(1);
                    beat_n.vld = 1'b1;
                    beat_n.val = d_b;
                    beat_n.sof = 1'b1;
                end else begin
                    disc_n = disc_q + CNT_W'(1);
                end
            end else begin
                if (cr_q) begin
                    cr_n = 1'b0;
                    em   = 1'b1;
                    if (d_b == CH_LF) begin
                        cl = 1'b1;
                    end else begin
                        eb = CH_CR;
                        rs = 1'b1;
                    end
                end else if (d_b == CH_CR) begin
                    cr_n = 1'b1;
                end else begin
                    em = 1'b1;
                    cl = (d_b == CH_LF);
                end
                if (em) begin
                    if (len_q == LEN_FULL) begin
                        beat_n.eof = 1'b1;
                        beat_n.ovf = 1'b1;
                        st_n       = FS_HUNT;
                        cr_n       = 1'b0;
                    end else begin
                        beat_n.vld = 1'b1;
                        beat_n.val = eb;
                        beat_n.eof = cl;
                        len_n      = len_q + LEN_W'(1);
                        if (cl) st_n = FS_HUNT;
                        sp_v_n = rs;
                        sp_b_n = d_b;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_HUNT;
            len_q  <= '0;
            cr_q   <= 1'b0;
            sp_v_q <= 1'b0;
            sp_b_q <= 8'h00;
            beat_q <= '0;
            disc_q <= '0;
        end else begin
            st_q   <= st_n;
            len_q  <= len_n;
            cr_q   <= cr_n;
            sp_v_q <= sp_v_n;
            sp_b_q <= sp_b_n;
            beat_q <= beat_n;
            disc_q <= disc_n;
        end
    end

    assign beat        = beat_q;
    assign discard_cnt = disc_q;

endmodule

// File: rtl/rec_framer.sv
module rec_framer
    import rec_framer_pkg::*;
#(
    parameter int NCTL    = 4,
    parameter int MAX_LEN = 16,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [NCTL*8-1:0] tab_char,
    input  logic [NCTL-1:0]   tab_en,
    input  logic [NCTL-1:0]   tab_rej,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_ovf,
    output logic              tx_pause,
    output logic              ctl_evt,
    output logic [7:0]        ctl_last,
    output logic [CNT_W-1:0]  discard_cnt
);

    tagged_byte_t tb;
    rec_beat_t    beat;

    rf_classify #(.NCTL(NCTL)) u_cls (
        .in_valid (in_valid),
        .in_data  (in_data),
        .tab_char (tab_char),
        .tab_en   (tab_en),
        .tab_rej  (tab_rej),
        .tb       (tb)
    );

    rf_side u_side (
        .clk      (clk),
        .rst      (rst),
        .tb       (tb),
        .tx_pause (tx_pause),
        .ctl_evt  (ctl_evt),
        .ctl_last (ctl_last)
    );

    rf_frame #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .tb          (tb),
        .beat        (beat),
        .discard_cnt (discard_cnt)
    );

    assign out_valid = beat.vld;
    assign out_data  = beat.val;
    assign out_sof   = beat.sof;
    assign out_eof   = beat.eof;
    assign out_ovf   = beat.ovf;

endmodule

// File: rtl/rec_framer_chk.sv
module rec_framer_chk #(
    parameter int MAX_LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sof,
    input logic       out_eof,
    input logic       out_ovf,
    input logic       tx_pause,
    input logic       ctl_evt,
    input logic [7:0] ctl_last
);

    localparam int LW = $clog2(MAX_LEN + 1) + 1;
    logic [LW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)                       seen <= '0;
        else if (out_eof)              seen <= '0;
        else if (out_valid && out_sof) seen <= LW'(1);
        else if (out_valid)            seen <= seen + LW'(1);
    end

    AST_IN_SPACING: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid); // R1
    AST_SOF_IS_START: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_valid && out_data == 8'h53)); // R2
    AST_NO_FLOW_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data != 8'h11 && out_data != 8'h13)); // R4
    AST_PAUSE_SET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == 8'h13) |=> tx_pause); // R5
    AST_PAUSE_CLR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == 8'h11) |=> !tx_pause); // R5
    AST_CTL_LATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rst) |=> (!ctl_evt || ctl_last == $past(in_data))); // R6
    AST_EOF_IS_LF: assert property (@(posedge clk) disable iff (rst)
        (out_eof && !out_ovf) |-> (out_valid && out_data == 8'h0A)); // R7
    AST_OVF_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_eof && !out_valid)); // R9
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sof) |-> (seen < LW'(MAX_LEN))); // R9

endmodule

bind rec_framer rec_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_ovf   (out_ovf),
    .tx_pause  (tx_pause),
    .ctl_evt   (ctl_evt),
    .ctl_last  (ctl_last)
);

// File: tb/rec_framer_tb.sv
module rec_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCTL    = 4;
    localparam int MAX_LEN = 16;
    localparam int CNT_W   = 8;

    typedef struct packed {
        logic [7:0] din;
        logic       v1;
        logic [7:0] d1;
        logic       sof;
        logic       eof;
        logic       ovf;
        logic       v2;
        logic [7:0] d2;
        logic       pause;
        logic       evt;
    } vec_t;

    function automatic vec_t mk(input logic [7:0] din, input logic v1, input logic [7:0] d1,
                                input logic sof, input logic eof, input logic ovf,
                                input logic v2, input logic [7:0] d2,
                                input logic pause, input logic evt);
        vec_t r;
        r.din = din; r.v1 = v1; r.d1 = d1; r.sof = sof; r.eof = eof; r.ovf = ovf;
        r.v2 = v2; r.d2 = d2; r.pause = pause; r.evt = evt;
        return r;
    endfunction

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        mk(8'h41, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R3 dropped in hunt
        mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), // R2 open
        mk(8'h13, 0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 0), // R4 R5 pause, table entry loses
        mk(8'h61, 1, 8'h61, 0, 0, 0, 0, 8'h00, 1, 0), // data
        mk(8'h23, 0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 1), // R6 rejected
        mk(8'h24, 1, 8'h24, 0, 0, 0, 0, 8'h00, 1, 0), // R6 enabled no reject
        mk(8'h25, 1, 8'h25, 0, 0, 0, 0, 8'h00, 1, 0), // R6 disabled entry
        mk(8'h11, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R5 resume
        mk(8'h0D, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R8 CR held
        mk(8'h62, 1, 8'h0D, 0, 0, 0, 1, 8'h62, 0, 0), // R8 CR then byte
        mk(8'h0D, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R8 held
        mk(8'h0A, 1, 8'h0A, 0, 1, 0, 0, 8'h00, 0, 0), // R7 R8 CR dropped
        mk(8'h78, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R3
        mk(8'h0A, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R3 LF in hunt
        mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), // R2
        mk(8'h0D, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R8
        mk(8'h13, 0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 0), // R4 pause between CR and LF
        mk(8'h0A, 1, 8'h0A, 0, 1, 0, 0, 8'h00, 1, 0), // R4 R8 CR still dropped
        mk(8'h11, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R5
        mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), // R2
        mk(8'h0D, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), // R8
        mk(8'h0D, 1, 8'h0D, 0, 0, 0, 0, 8'h00, 0, 0), // R8 second CR held again
        mk(8'h0A, 1, 8'h0A, 0, 1, 0, 0, 8'h00, 0, 0)  // R7
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [7:0]        in_data;
    logic [NCTL*8-1:0] tab_char;
    logic [NCTL-1:0]   tab_en;
    logic [NCTL-1:0]   tab_rej;
    logic              out_valid, out_sof, out_eof, out_ovf, tx_pause, ctl_evt;
    logic [7:0]        out_data, ctl_last;
    logic [CNT_W-1:0]  discard_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rec_framer #(.NCTL(NCTL), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .tab_char(tab_char), .tab_en(tab_en), .tab_rej(tab_rej),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_ovf(out_ovf), .tx_pause(tx_pause),
        .ctl_evt(ctl_evt), .ctl_last(ctl_last), .discard_cnt(discard_cnt)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input vec_t v, input string tag);
        in_valid = 1'b1;
        in_data  = v.din;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " first cycle"},
              {19'd0, out_valid, out_valid ? out_data : 8'h00, out_sof, out_eof, out_ovf, tx_pause, ctl_evt},
              {19'd0, v.v1, v.d1, v.sof, v.eof, v.ovf, v.pause, v.evt});
        @(negedge clk);
        check({tag, " second cycle"},
              {21'd0, out_valid, out_valid ? out_data : 8'h00, out_sof, out_eof},
              {21'd0, v.v2, v.d2, 1'b0, 1'b0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = 8'h00;
        tab_char = {8'h13, 8'h25, 8'h24, 8'h23};
        tab_en   = 4'b1011;
        tab_rej  = 4'b1101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 reset strobes", {26'd0, out_valid, out_sof, out_eof, out_ovf, tx_pause, ctl_evt}, 32'd0);
        check("R10 reset regs", {16'd0, ctl_last, discard_cnt}, 32'd0);

        for (int i = 0; i < NV; i++) step(VEC[i], $sformatf("vector %0d", i));

        check("R3 discard count", {24'd0, discard_cnt}, 32'd3);
        check("R6 last control char", {24'd0, ctl_last}, 32'h23);

        // R9 overflow: S plus 15 bytes fills the record, LF overflows
        step(mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), "R9 open");
        for (int k = 0; k < MAX_LEN - 1; k++)
            step(mk(8'h61, 1, 8'h61, 0, 0, 0, 0, 8'h00, 0, 0), $sformatf("R9 fill %0d", k));
        step(mk(8'h0A, 0, 8'h00, 0, 1, 1, 0, 8'h00, 0, 0), "R9 overflow close");
        step(mk(8'h61, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), "R9 back to hunt");
        check("R9 R3 discard after overflow", {24'd0, discard_cnt}, 32'd4);

        // R8 overflow on held CR emission drops the following byte
        step(mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), "R8 open");
        for (int k = 0; k < MAX_LEN - 1; k++)
            step(mk(8'h62, 1, 8'h62, 0, 0, 0, 0, 8'h00, 0, 0), $sformatf("R8 fill %0d", k));
        step(mk(8'h0D, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), "R8 CR at full");
        step(mk(8'h63, 0, 8'h00, 0, 1, 1, 0, 8'h00, 0, 0), "R9 CR overflow");
        check("R9 no discard of overflow byte", {24'd0, discard_cnt}, 32'd4);

        // R10 reset inside an open record with pause set
        step(mk(8'h53, 1, 8'h53, 1, 0, 0, 0, 8'h00, 0, 0), "R10 open");
        step(mk(8'h13, 0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 0), "R10 pause");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid-record reset", {15'd0, tx_pause, ctl_last, discard_cnt}, 32'd0);
        step(mk(8'h61, 0, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0), "R10 hunt after reset");
        check("R10 R3 discard after reset", {24'd0, discard_cnt}, 32'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule